// File: doc/BRIEF.md
# Buck Converter Soft-Start and Fault Sequencer

This block sequences start-up and fault recovery for a voltage-mode buck controller. It does nothing until the supply comparator reports a good supply. It then enables switching and raises a digital reference code from zero to the regulation target in equal steps. The whole ramp lasts a fixed number of clock cycles, whatever the converter's input and output voltages are.

The block handles four kinds of fault, and all of their inputs are comparator bits.
- **Over-current.** Each over-current event stops switching and starts a fresh ramp. The fourth event latches the block off.
- **Under-voltage.** An under-voltage in regulation starts a timed hiccup pause and then a new ramp. This never latches, and under-voltage is ignored while a ramp is running.
- **Over-voltage.** An over-voltage reading asks the gate logic to hold the low-side switch on for as long as the reading persists.
- **Shutdown.** An external shutdown request stops switching and clears the strike count. Releasing it starts a new ramp.

Loss of supply-good clears every state.

Top module: `softstart_fault_seq`

## Requirements
- R1: While `supply_ok` is low, and one cycle after it falls, `sw_en`, `force_low` and `latched_off` are 0 and `ref_code` is 0. Loss of supply clears the latched-off state and the strike count.
- R2: The first clock edge that sees `supply_ok` high with `shdn_req` low, starting from the waiting state, sets `sw_en` to 1 with `ref_code` still 0.
- R3: During a ramp, `ref_code` rises by `STEP` every `STEP_CYC` cycles. The first rise comes `STEP_CYC` cycles after the ramp starts, and the code never exceeds `TARGET`.
- R4: Once `ref_code` reaches `TARGET`, the block enters regulation on the next edge and holds `ref_code` at `TARGET`.
- R5: An `oc_trip` sampled while switching drops `sw_en` and clears `ref_code` for exactly one cycle, then a new ramp starts from 0.
- R6: The `OC_LIMIT`-th counted over-current event (default 4) sets `latched_off` to 1 and holds `sw_en` at 0.
- R7: While latched off, `uv_trip`, `oc_trip` and `ov_trip` have no effect: `sw_en` and `force_low` stay 0 and `latched_off` stays 1.
- R8: `shdn_req` has priority over every fault. It forces `sw_en` to 0, clears `latched_off` and the strike count, and its release starts a ramp on the next edge.
- R9: A `uv_trip` sampled in regulation drops `sw_en` for `HICCUP_CYC` cycles, after which a new ramp starts. The strike count is not affected.
- R10: A `uv_trip` during a ramp, before the target is reached, is ignored and switching continues.
- R11: `force_low` follows `ov_trip` with one cycle of latency, but only while switching. It is never asserted while `sw_en` is 0.
- R12: Whenever `sw_en` is 0, `ref_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply comparator above its rising threshold |
| oc_trip | input | 1 | Over-current comparator, already qualified to the low-side on-time |
| uv_trip | input | 1 | Feedback below the under-voltage threshold |
| ov_trip | input | 1 | Feedback above the over-voltage threshold |
| shdn_req | input | 1 | External shutdown request |
| ref_code | output | REF_W | Reference code for the error amplifier |
| sw_en | output | 1 | Switching enable for the modulator |
| force_low | output | 1 | Request to hold the low-side switch on |
| latched_off | output | 1 | Over-current limit reached; output floating |

## Verification
The bench checks that the strike count is cleared by shutdown by requiring four fresh events after a shutdown before the block latches again. A counter that is not cleared would latch after the first event.

It drives under-voltage in the middle of a ramp, where a missing mask would cause a spurious hiccup. It also checks the exact length of the hiccup pause, which an off-by-one timer would stretch or shorten by one cycle.

While the block is latched off, it drives under-voltage, over-current and over-voltage together. A design that leaks any of them would restart switching or raise `force_low`.

It samples the first ramp step and the target crossing on exact cycles, which catches a ramp clear timed from the wrong state.

// File: rtl/sst_pkg.sv
// Shared types for the soft-start / fault sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sst_pkg;

    typedef enum logic [2:0] {
        SEQ_WAIT    = 3'd0,   // waiting for supply-good
        SEQ_RAMP    = 3'd1,   // soft-start ramp in progress
        SEQ_REG     = 3'd2,   // regulating at target
        SEQ_RESTART = 3'd3,   // one idle cycle after an over-current strike
        SEQ_HICCUP  = 3'd4,   // under-voltage pause
        SEQ_SHDN    = 3'd5,   // external shutdown held
        SEQ_LATCH   = 3'd6    // over-current limit reached
    } seq_state_t;

    // True for the states in which the power stage switches.
    function automatic logic is_switching(input seq_state_t s);
        return (s == SEQ_RAMP) || (s == SEQ_REG);
    endfunction

endpackage

// File: rtl/sst_ramp.sv
// Reference ramp generator.
// Raises the code by STEP every STEP_CYC enabled cycles and saturates at TARGET.
// Assumes: clear has priority over run; code holds while run is low.
module sst_ramp #(
    parameter int REF_W    = 10,
    parameter int TARGET   = 640,
    parameter int STEP     = 1,
    parameter int STEP_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [REF_W-1:0] code,
    output logic             at_target
);
    localparam int TICK_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [REF_W:0] TGT_W = (REF_W+1)'(TARGET);
    localparam logic [REF_W:0] STP_W = (REF_W+1)'(STEP);

    logic           step_now;
    logic [REF_W:0] sum;

    // Pick the step strobe: a divider for multi-cycle steps, or every cycle otherwise.
    generate
        if (STEP_CYC > 1) begin : g_div
            logic [TICK_W-1:0] tick;
            // Count enabled cycles between steps.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    tick <= '0;
                end else if (run) begin
                    tick <= (tick == TICK_W'(STEP_CYC-1)) ? '0 : tick + 1'b1;
                end
            end
            assign step_now = run && (tick == TICK_W'(STEP_CYC-1));
        end else begin : g_nodiv
            assign step_now = run;
        end
    endgenerate

    // Next code candidate, computed one bit wider so saturation is exact.
    always_comb sum = {1'b0, code} + STP_W;

    // Advance the code, saturating at the target.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            code <= '0;
        end else if (step_now) begin
            code <= (sum >= TGT_W) ? TGT_W[REF_W-1:0] : sum[REF_W-1:0];
        end
    end

    assign at_target = ({1'b0, code} == TGT_W);

endmodule

// File: rtl/sst_strike_cnt.sv
// Over-current strike counter.
// Counts strikes up to LIMIT and flags when the next strike would reach it.
// Assumes: clear has priority over strike.
module sst_strike_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic strike,
    output logic last_strike
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    // Count strikes, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (strike && (cnt != CNT_W'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last_strike = (cnt >= CNT_W'(LIMIT - 1));

endmodule

// File: rtl/sst_hiccup_timer.sv
// Under-voltage hiccup delay timer.
// Runs while enabled and flags the last cycle of a DELAY-cycle pause.
// Assumes: the timer is restarted by dropping enable.
module sst_hiccup_timer #(
    parameter int DELAY = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int T_W = (DELAY > 1) ? $clog2(DELAY) : 1;

    logic [T_W-1:0] cnt;

    // Count cycles spent in the pause; reset whenever the pause is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt != T_W'(DELAY - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = en && (cnt == T_W'(DELAY - 1));

endmodule

// File: rtl/softstart_fault_seq.sv
// Soft-start and protection fault sequencer (top).
// Sequences start-up, over-current retry/latch, under-voltage hiccup,
// over-voltage low-side clamp and external shutdown.
// Assumes: all fault inputs are already synchronous to clk; oc_trip is
// already qualified to the low-side on-time.
module softstart_fault_seq #(
    parameter int REF_W      = 10,
    parameter int TARGET     = 640,
    parameter int STEP       = 1,
    parameter int STEP_CYC   = 5,
    parameter int HICCUP_CYC = 2000,
    parameter int OC_LIMIT   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             oc_trip,
    input  logic             uv_trip,
    input  logic             ov_trip,
    input  logic             shdn_req,
    output logic [REF_W-1:0] ref_code,
    output logic             sw_en,
    output logic             force_low,
    output logic             latched_off
);
    import sst_pkg::*;

    seq_state_t state, nxt;
    logic       at_target;
    logic       last_strike;
    logic       hic_done;
    logic       oc_event;
    logic       strike_clr;
    logic       force_q;

    // An over-current counts only while the stage switches and no higher-priority input is active.
    always_comb oc_event = oc_trip && is_switching(state) && supply_ok && !shdn_req;
    always_comb strike_clr = !supply_ok || shdn_req;

    // Next-state decision: supply loss, then shutdown, then over-current, then under-voltage.
    always_comb begin
        nxt = state;
        if (!supply_ok) begin
            nxt = SEQ_WAIT;
        end else if (shdn_req) begin
            nxt = SEQ_SHDN;
        end else begin
            unique case (state)
                SEQ_WAIT, SEQ_SHDN, SEQ_RESTART: nxt = SEQ_RAMP;
                SEQ_RAMP: begin
                    if (oc_trip)        nxt = last_strike ? SEQ_LATCH : SEQ_RESTART;
                    else if (at_target) nxt = SEQ_REG;
                end
                SEQ_REG: begin
                    if (oc_trip)        nxt = last_strike ? SEQ_LATCH : SEQ_RESTART;
                    else if (uv_trip)   nxt = SEQ_HICCUP;
                end
                SEQ_HICCUP: if (hic_done) nxt = SEQ_RAMP;
                SEQ_LATCH:  nxt = SEQ_LATCH;
                default:    nxt = SEQ_WAIT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_WAIT;
        else        state <= nxt;
    end

    // Over-voltage clamp request, registered and gated by the coming switching state.
    always_ff @(posedge clk) begin
        if (!rst_n) force_q <= 1'b0;
        else        force_q <= ov_trip && is_switching(nxt);
    end

    sst_ramp #(
        .REF_W(REF_W), .TARGET(TARGET), .STEP(STEP), .STEP_CYC(STEP_CYC)
    ) u_ramp (
        .clk(clk), .rst_n(rst_n),
        .clear(!is_switching(nxt)),
        .run(is_switching(state)),
        .code(ref_code), .at_target(at_target)
    );

    sst_strike_cnt #(.LIMIT(OC_LIMIT)) u_strike (
        .clk(clk), .rst_n(rst_n),
        .clear(strike_clr), .strike(oc_event),
        .last_strike(last_strike)
    );

    sst_hiccup_timer #(.DELAY(HICCUP_CYC)) u_hic (
        .clk(clk), .rst_n(rst_n),
        .en(state == SEQ_HICCUP),
        .done(hic_done)
    );

    assign sw_en       = is_switching(state);
    assign force_low   = force_q;
    assign latched_off = (state == SEQ_LATCH);

endmodule

// File: rtl/sst_checker.sv
// Port-level assertion checker for softstart_fault_seq, attached by bind.
// Assumes: synchronous active-low reset held from time zero.
module sst_checker #(
    parameter int REF_W  = 10,
    parameter int TARGET = 640
) (
    input logic             clk,
    input logic             rst_n,
    input logic             supply_ok,
    input logic             oc_trip,
    input logic             uv_trip,
    input logic             shdn_req,
    input logic [REF_W-1:0] ref_code,
    input logic             sw_en,
    input logic             force_low,
    input logic             latched_off
);
    localparam logic [REF_W-1:0] TGT = REF_W'(TARGET);

    AST_SUPPLY_LOSS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!sw_en && !latched_off && !force_low && ref_code == '0)); // R1
    AST_REF_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code <= TGT); // R3
    AST_REF_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && $past(sw_en)) |-> (ref_code >= $past(ref_code))); // R3
    AST_OC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && oc_trip && supply_ok && !shdn_req) |=> (!sw_en && ref_code == '0)); // R5
    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        latched_off |-> (!sw_en && !force_low)); // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && supply_ok && !shdn_req) |=> latched_off); // R7
    AST_SHDN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req |=> (!sw_en && !latched_off)); // R8
    AST_UV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && ref_code < TGT && uv_trip && !oc_trip && supply_ok && !shdn_req) |=> sw_en); // R10
    AST_FORCE_NEEDS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        force_low |-> sw_en); // R11
    AST_OFF_REF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> (ref_code == '0)); // R12

endmodule

bind softstart_fault_seq sst_checker #(.REF_W(REF_W), .TARGET(TARGET)) u_sst_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .oc_trip(oc_trip),
    .uv_trip(uv_trip), .shdn_req(shdn_req), .ref_code(ref_code),
    .sw_en(sw_en), .force_low(force_low), .latched_off(latched_off)
);

// File: tb/tb_softstart_fault_seq.sv
`timescale 1ns/1ps
module tb_softstart_fault_seq;
    localparam int REF_W = 10, TARGET = 40, STEP = 4, STEP_CYC = 3, HIC = 20, OCL = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic supply_ok = 0, oc_trip = 0, uv_trip = 0, ov_trip = 0, shdn_req = 0;
    logic [REF_W-1:0] ref_code;
    logic sw_en, force_low, latched_off;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    softstart_fault_seq #(.REF_W(REF_W), .TARGET(TARGET), .STEP(STEP),
        .STEP_CYC(STEP_CYC), .HICCUP_CYC(HIC), .OC_LIMIT(OCL)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .oc_trip(oc_trip),
        .uv_trip(uv_trip), .ov_trip(ov_trip), .shdn_req(shdn_req),
        .ref_code(ref_code), .sw_en(sw_en), .force_low(force_low),
        .latched_off(latched_off));

    typedef struct packed {
        logic       sup, oc, uv, ov, sd;
        logic [7:0] n;
        logic       sw, lat, fl, chk_ref;
        logic [9:0] rf;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1,0,0,0,0,  1, 1,0,0,1,  0,  2}, // R2 start
        '{1,0,0,0,0,  3, 1,0,0,1,  4,  3}, // R3 first step
        '{1,0,0,0,0, 27, 1,0,0,1, 40,  3}, // R3 target reached
        '{1,0,0,0,0,  1, 1,0,0,1, 40,  4}, // R4 regulation
        '{1,0,0,0,0, 20, 1,0,0,1, 40,  4}, // R4 hold
        '{1,0,1,0,0,  1, 0,0,0,1,  0,  9}, // R9 hiccup entry
        '{1,0,0,0,0, 19, 0,0,0,1,  0,  9}, // R9 still paused
        '{1,0,0,0,0,  1, 1,0,0,1,  0,  9}, // R9 new ramp
        '{1,0,1,0,0,  5, 1,0,0,1,  4, 10}, // R10 uv masked
        '{1,0,0,1,0,  1, 1,0,1,1,  8, 11}, // R11 clamp
        '{1,0,0,0,0,  1, 1,0,0,1,  8, 11}, // R11 release
        '{1,1,0,0,0,  1, 0,0,0,1,  0,  5}, // R5 strike 1
        '{1,0,0,0,0,  1, 1,0,0,1,  0,  5}, // R5 ramp again
        '{1,1,0,0,0,  1, 0,0,0,1,  0,  5}, // R5 strike 2
        '{1,0,0,0,0,  1, 1,0,0,0,  0,  5},
        '{1,1,0,0,0,  1, 0,0,0,1,  0,  5}, // R5 strike 3
        '{1,0,0,0,0,  1, 1,0,0,0,  0,  5},
        '{1,1,0,0,0,  1, 0,1,0,1,  0,  6}, // R6 fourth strike latches
        '{1,0,1,0,0,  3, 0,1,0,1,  0,  7}, // R7 uv ignored
        '{1,1,0,1,0,  2, 0,1,0,1,  0,  7}, // R7 oc/ov ignored
        '{1,0,0,0,1,  1, 0,0,0,1,  0,  8}, // R8 shutdown unlatches
        '{1,0,0,0,0,  1, 1,0,0,1,  0,  8}, // R8 release ramps
        '{1,1,0,0,0,  1, 0,0,0,1,  0,  8}, // R8 count cleared: strike 1
        '{1,0,0,0,0,  1, 1,0,0,0,  0,  8},
        '{1,1,0,0,0,  1, 0,0,0,0,  0,  8},
        '{1,0,0,0,0,  1, 1,0,0,0,  0,  8},
        '{1,1,0,0,0,  1, 0,0,0,0,  0,  8}, // R8 third strike not latched
        '{1,0,0,0,0,  1, 1,0,0,0,  0,  8},
        '{1,1,0,0,0,  1, 0,1,0,0,  0,  6}, // R6 fourth strike
        '{0,0,0,0,0,  1, 0,0,0,1,  0,  1}, // R1 supply loss clears latch
        '{1,0,0,0,0,  1, 1,0,0,1,  0,  2}  // R2 restart
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic outs(input string tag, input bit sw, input bit lat, input bit fl);
        chk(tag, "sw_en", int'(sw_en), int'(sw));
        chk(tag, "latched_off", int'(latched_off), int'(lat));
        chk(tag, "force_low", int'(force_low), int'(fl));
    endtask

    task automatic drive(input bit sup, input bit oc, input bit uv, input bit ov, input bit sd,
                         input int n);
        supply_ok = sup; oc_trip = oc; uv_trip = uv; ov_trip = ov; shdn_req = sd;
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        outs("R1 reset", 0, 0, 0);
        chk("R1 reset", "ref_code", int'(ref_code), 0);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 6);
        outs("R1 no supply", 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            drive(VECS[i].sup, VECS[i].oc, VECS[i].uv, VECS[i].ov, VECS[i].sd, int'(VECS[i].n));
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            outs(tag, VECS[i].sw, VECS[i].lat, VECS[i].fl);
            if (VECS[i].chk_ref) chk(tag, "ref_code", int'(ref_code), int'(VECS[i].rf));
        end

        // R11: clamp held while over-voltage persists in regulation.
        drive(1, 0, 0, 0, 0, 40);
        chk("R4 settle", "ref_code", int'(ref_code), TARGET);
        drive(1, 0, 0, 1, 0, 4);
        outs("R11 held", 1, 0, 1);
        drive(1, 0, 0, 0, 0, 1);
        outs("R11 dropped", 1, 0, 0);

        // R1: synchronous reset in regulation.
        rst_n = 1'b0;
        @(negedge clk);
        outs("R1 mid reset", 0, 0, 0);
        chk("R1 mid reset", "ref_code", int'(ref_code), 0);
        rst_n = 1'b1;

        // R8: shutdown held while supply is good blocks start-up.
        drive(1, 0, 0, 1, 1, 5);
        outs("R8 held off", 0, 0, 0);
        chk("R8 held off", "ref_code", int'(ref_code), 0);
        drive(1, 1, 0, 0, 1, 1);
        outs("R8 beats oc", 0, 0, 0);
        drive(1, 0, 0, 0, 0, 1);
        outs("R8 release", 1, 0, 0);
        chk("R12 ramp start", "ref_code", int'(ref_code), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule